// File: doc/BRIEF.md
# I2C Register Read Target

This block is an I2C target that lets an external bus master read a small register file inside the chip. SCL and SDA arrive as plain inputs. They are taken into the system clock domain, and the block pulls SDA low through a single open-drain enable. The target's 7-bit bus address is the fixed pattern `100100` in bits 6..1. Bit 0 comes from a strap input, so two targets can share one bus.

A master first sends a write-direction address followed by one byte, which the target keeps as its register pointer. The master then issues a repeated start and a read-direction address, and the target shifts out the byte at that pointer. The pointer is kept after the transfer ends. A later read-direction address, whether it follows a fresh start or a repeated start, returns the same register without another pointer phase. Register contents are fetched through a combinational parallel port: the block presents the pointer and samples the data byte when it begins each transmit byte.

Top module: `i2c_regptr_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal `{6'b100100, addr_sel}`. Bit 0 of that byte is the direction: 0 is write, 1 is read. The acknowledge is a low SDA level during the ninth SCL pulse.
- R2: SDA falling while SCL is high is a start, and SDA rising while SCL is high is a stop. A start seen in any state, including a repeated start with no stop before it, begins a new address byte.
- R3: Every address, pointer and data byte is transferred most significant bit first, eight bits per byte.
- R4: In a write-direction transfer, the first byte after the address is acknowledged and stored as the pointer. It then appears on `reg_addr`.
- R5: After a read-direction address is acknowledged, the target shifts out `reg_data` for the current pointer. It pulls SDA low only for the 0 bits.
- R6: A master NACK (SDA high in the ninth pulse after a data byte) ends transmission. The target then leaves SDA released until the next start.
- R7: A master ACK after a data byte makes the target send the register at the same pointer again. The pointer does not advance.
- R8: A read-direction address with no pointer phase, whether after a repeated start or a new start, returns data from the last stored pointer.
- R9: After an address byte that does not match, the target sends no acknowledge, ignores all following bytes and keeps its pointer, until the next start.
- R10: The target releases SDA during the master's ACK/NACK slot and after a stop. It does not acknowledge any byte after the pointer byte.
- R11: While reset is active, `sda_oe` is 0 and the pointer is 0.
- R12: `sda_oe` changes only while SCL is low, after a falling SCL edge has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_sel | input | 1 | Strap that sets bit 0 of the bus address |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 8 | Stored register pointer, to the register file |
| reg_data | input | 8 | Register contents at `reg_addr` |

## Verification
A wrong state in the byte sequencer shows up on the very next ninth clock pulse: a missing or extra acknowledge, or a data bit driven into the master's ACK slot. A bit counter that is off by one shows as rotated data in the first byte read. A corrupted or wrongly retained pointer shows on `reg_addr` as soon as the pointer byte is acknowledged. It also shows in the first read that has no pointer phase. A drive change while SCL is high would look like a false start or stop to other devices, so the bench flags it on the system clock cycle where it occurs.

// File: rtl/i2c_tgt_pkg.sv
// Shared types and constants for the I2C register read target.
package i2c_tgt_pkg;

    // Fixed upper six bits of the 7-bit target address.
    localparam logic [5:0] TGT_ADDR_HI = 6'b100100;

    // Sequencer states of the target.
    typedef enum logic [2:0] {
        ST_IDLE,      // bus free, waiting for a start
        ST_ADDR,      // receiving the address byte
        ST_ACK_ADDR,  // driving the address acknowledge
        ST_PTR,       // receiving the pointer byte
        ST_ACK_PTR,   // driving the pointer acknowledge
        ST_TX,        // shifting out a data byte
        ST_MACK,      // master's ACK/NACK slot
        ST_HOLD       // not addressed or done: ignore until start
    } tgt_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes one bus line into the system clock domain and flags its edges.
// Assumes the line idles high; the reset value matches so no false edge appears.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] pipe_q;
    logic              last_q;

    // Shift the raw line through the synchronizer chain.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[g] <= 1'b1;
                else if (g == 0) pipe_q[g] <= line_i;
                else pipe_q[g] <= pipe_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= pipe_q[STAGES-1];
    end

    assign lvl_o  = pipe_q[STAGES-1];
    assign rise_o = pipe_q[STAGES-1] & ~last_q;
    assign fall_o = ~pipe_q[STAGES-1] & last_q;

    AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> !$past(lvl_o)); // R12

endmodule

// File: rtl/i2c_bus_cond.sv
// Detects start and stop conditions from synchronized SCL/SDA.
// Assumes SCL and SDA pass through synchronizers of equal depth.
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o
);
    // A data edge while the clock is high is a bus condition.
    always_comb begin
        start_o = scl_lvl & sda_fall;
        stop_o  = scl_lvl & sda_rise;
    end

    AST_COND_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o || stop_o) |-> $past(scl_lvl)); // R2

endmodule

// File: rtl/i2c_tgt_fsm.sv
// Byte sequencer of the target: address match, pointer capture, data shift-out
// and acknowledge handling. Samples SDA on SCL rising edges and changes its
// drive only on SCL falling edges. Register data is read combinationally.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_c,
    input  logic              stop_c,
    input  logic              addr_sel,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sda_oe,
    output logic [DATA_W-1:0] ptr_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

    tgt_state_t        state_q;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              rw_q;
    logic              mnack_q;
    logic              oe_q;
    logic [DATA_W-1:0] ptr_q;
    logic [DATA_W-2:0] own_addr;

    assign own_addr = {TGT_ADDR_HI, addr_sel};

    // Sequence bytes, acknowledges and drive level on bus events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            cnt_q   <= '0;
            rw_q    <= 1'b0;
            mnack_q <= 1'b1;
            oe_q    <= 1'b0;
            ptr_q   <= '0;
        end else if (start_c) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
        end else if (stop_c) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg_q <= {shreg_q[DATA_W-2:0], sda_lvl};
                        cnt_q   <= cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == LAST_BIT) begin
                        if (shreg_q[DATA_W-1:1] == own_addr) begin
                            rw_q    <= shreg_q[0];
                            oe_q    <= 1'b1;
                            state_q <= ST_ACK_ADDR;
                        end else begin
                            state_q <= ST_HOLD;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (scl_fall) begin
                        cnt_q <= '0;
                        if (rw_q) begin
                            shreg_q <= rd_data;
                            oe_q    <= ~rd_data[DATA_W-1];
                            state_q <= ST_TX;
                        end else begin
                            oe_q    <= 1'b0;
                            state_q <= ST_PTR;
                        end
                    end
                end
                ST_PTR: begin
                    if (scl_rise) begin
                        shreg_q <= {shreg_q[DATA_W-2:0], sda_lvl};
                        cnt_q   <= cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == LAST_BIT) begin
                        ptr_q   <= shreg_q;
                        oe_q    <= 1'b1;
                        state_q <= ST_ACK_PTR;
                    end
                end
                ST_ACK_PTR: begin
                    if (scl_fall) begin
                        oe_q    <= 1'b0;
                        state_q <= ST_HOLD;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        cnt_q <= cnt_q + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt_q == LAST_BIT) begin
                            oe_q    <= 1'b0;
                            state_q <= ST_MACK;
                        end else begin
                            shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
                            oe_q    <= ~shreg_q[DATA_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        mnack_q <= sda_lvl;
                    end else if (scl_fall) begin
                        if (mnack_q) begin
                            state_q <= ST_HOLD;
                        end else begin
                            cnt_q   <= '0;
                            shreg_q <= rd_data;
                            oe_q    <= ~rd_data[DATA_W-1];
                            state_q <= ST_TX;
                        end
                    end
                end
                ST_HOLD: ;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sda_oe = oe_q;
    assign ptr_o  = ptr_q;

    AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_q != $past(oe_q)) |-> $past(scl_fall || start_c || stop_c)); // R12
    AST_PTR_FROM_PTR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q != $past(ptr_q)) |-> ($past(state_q) == ST_PTR)); // R4
    AST_QUIET_WHEN_UNADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_HOLD) |-> !oe_q); // R9
    AST_BIT_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_BIT); // R3
    AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK_ADDR && $past(state_q) == ST_ADDR)
            |-> ($past(shreg_q[DATA_W-1:1]) == $past(own_addr))); // R1
    AST_MASTER_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MACK) |-> !oe_q); // R10

endmodule

// File: rtl/i2c_regptr_target.sv
// Top of the I2C register read target. Synchronizes the bus lines, detects
// bus conditions and runs the byte sequencer. Assumes the system clock is at
// least 16 times faster than SCL so every SCL phase spans several samples.
module i2c_regptr_target #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel,
    output logic              sda_oe,
    output logic [DATA_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_data
);
    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_c, stop_c;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    i2c_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl),
        .sda_rise(sda_rise), .sda_fall(sda_fall),
        .start_o(start_c), .stop_o(stop_c)
    );

    i2c_tgt_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
        .start_c(start_c), .stop_c(stop_c), .addr_sel(addr_sel),
        .rd_data(reg_data), .sda_oe(sda_oe), .ptr_o(reg_addr)
    );

endmodule

// File: tb/sim_i2c_regptr_target.sv
`timescale 1ns/1ps
module sim_i2c_regptr_target;
    localparam int Q = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_low_m = 1'b0;
    logic       addr_sel = 1'b0;
    logic       sda_oe;
    logic [7:0] reg_addr;
    logic [7:0] reg_data;
    logic       sda_line;

    int checks = 0;
    int fails  = 0;
    int r12_viol = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t       exp_q[$];
    logic [7:0] obs_val;
    event       obs_ev;

    always #4 clk = ~clk;

    function automatic logic [7:0] regval(input logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'hA5;
    endfunction

    assign reg_data = regval(reg_addr);
    assign sda_line = ~(sda_low_m | sda_oe);

    i2c_regptr_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel(addr_sel), .sda_oe(sda_oe),
        .reg_addr(reg_addr), .reg_data(reg_data)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: pop one expected item per observed result.
    initial forever begin
        @(obs_ev);
        if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL scoreboard actual=%02h expected=none", obs_val);
        end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(obs_val, e.val, e.tag);
        end
    end

    // R12: target drive must never change while SCL is high.
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe !== prev_oe && scl_m) r12_viol++;
        prev_oe <= sda_oe;
    end

    task automatic qwait; repeat (Q) @(negedge clk); endtask

    task automatic bit_xfer(input logic b, output logic s);
        qwait; sda_low_m = ~b; qwait; scl_m = 1'b1; qwait;
        s = sda_line; qwait; scl_m = 1'b0;
    endtask

    task automatic bus_start;
        sda_low_m = 1'b0; scl_m = 1'b1; qwait;
        sda_low_m = 1'b1; qwait; scl_m = 1'b0;
    endtask

    task automatic bus_rstart;
        qwait; sda_low_m = 1'b0; qwait; scl_m = 1'b1; qwait;
        sda_low_m = 1'b1; qwait; scl_m = 1'b0;
    endtask

    task automatic bus_stop;
        qwait; sda_low_m = 1'b1; qwait; scl_m = 1'b1; qwait;
        sda_low_m = 1'b0; qwait;
    endtask

    // Driver: send a byte, expect the target's ack bit (0 = ack).
    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        logic s;
        exp_q.push_back('{val: {7'd0, exp_ack}, tag: tag});
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
        bit_xfer(1'b1, s);
        obs_val = {7'd0, s};
        -> obs_ev;
    endtask

    // Driver: read a byte, expect its value, then answer ack (0) or nack (1).
    task automatic recv_byte(input logic [7:0] exp, input logic mack, input string tag);
        logic s;
        logic [7:0] v;
        exp_q.push_back('{val: exp, tag: tag});
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, s);
            v[i] = s;
        end
        obs_val = v;
        -> obs_ev;
        bit_xfer(mack, s);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check({7'd0, sda_oe}, 8'h00, "R11 sda_oe in reset");
        check(reg_addr, 8'h00, "R11 pointer in reset");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Pointer write then combined read.
        bus_start;
        send_byte(8'h90, 1'b0, "R1 write address ack");
        send_byte(8'h81, 1'b0, "R4 pointer ack");
        check(reg_addr, 8'h81, "R4 R3 pointer stored msb first");
        bus_rstart;
        send_byte(8'h91, 1'b0, "R2 read address after repeated start");
        recv_byte(regval(8'h81), 1'b1, "R5 data at pointer");
        bus_stop;
        check({7'd0, sda_oe}, 8'h00, "R10 released after stop");

        // Read with no pointer phase, ack then nack.
        bus_start;
        send_byte(8'h91, 1'b0, "R8 read address ack");
        recv_byte(regval(8'h81), 1'b0, "R8 retained pointer");
        recv_byte(regval(8'h81), 1'b1, "R7 same register after ack");
        recv_byte(8'hFF, 1'b1, "R6 bus released after nack");
        bus_stop;

        // Non-matching address.
        bus_start;
        send_byte(8'h92, 1'b1, "R9 mismatch not acked");
        send_byte(8'h33, 1'b1, "R9 following byte ignored");
        check(reg_addr, 8'h81, "R9 pointer kept");
        bus_stop;

        // Strap set: address becomes 1001001.
        addr_sel = 1'b1;
        bus_start;
        send_byte(8'h92, 1'b0, "R1 strap address ack");
        send_byte(8'h3C, 1'b0, "R4 second pointer ack");
        send_byte(8'h55, 1'b1, "R10 extra byte not acked");
        check(reg_addr, 8'h3C, "R4 second pointer");
        bus_rstart;
        send_byte(8'h93, 1'b0, "R2 repeated start read");
        recv_byte(regval(8'h3C), 1'b1, "R5 second data");
        bus_rstart;
        send_byte(8'h92, 1'b0, "R2 write after nack and repeated start");
        send_byte(8'h07, 1'b0, "R4 third pointer ack");
        bus_rstart;
        send_byte(8'h93, 1'b0, "R8 read after repeated start");
        recv_byte(regval(8'h07), 1'b1, "R5 R3 third data");
        bus_stop;

        // Old address no longer matches.
        bus_start;
        send_byte(8'h90, 1'b1, "R1 strap excludes old address");
        bus_stop;

        repeat (10) @(negedge clk);
        check(r12_viol[7:0], 8'h00, "R12 drive changes only with SCL low");
        check(exp_q.size() == 0 ? 8'h00 : 8'h01, 8'h00, "scoreboard drained");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule